// File: doc/BRIEF.md
# Legacy DMA Controller Register File

This block is the host-side register set of a four-channel DMA controller reached over an 8-bit I/O port bus. Each channel keeps a 16-bit base and current address and a 16-bit base and current count. Both are reached one byte at a time through a single port per register. A shared byte pointer picks the low or high half. The block also holds a command byte, a request bit per channel, a mask bit per channel and a 6-bit mode field per channel. It decodes the write-only strobes that clear the pointer, clear all masks, load all masks and clear the whole controller. Reads return the status byte and the live current address or count.

The transfer engine sees the mode fields, the mask bits and the command byte. It advances a channel by pulsing `step_i` with a channel index. On each accepted step the register file moves that channel's current address up or down by one and lowers its count. When a step meets a count of zero it raises terminal count. It then either reloads the channel from its base registers or masks the channel.

Bus reads are combinational in the cycle `bus_rd_i` is high. All register updates, pointer toggles and read side effects take effect at the rising clock edge that ends the access.

Top module: `dma_regfile`

## Requirements
- R1: After reset all four mask bits are set, command, request and terminal-count status are zero, every address and count register is zero, and the byte pointer selects the low byte.
- R2: Every read or write at a channel port (offsets 0 to 7) transfers the byte picked by the pointer (low byte first) and toggles the pointer at the end of the access.
- R3: A write to offset 0x0C returns the pointer to the low byte, whatever the data.
- R4: Channel n's address port is offset 2n and its count port 2n+1. A write loads the byte into both the base and the current register. A read returns the byte of the current register, and `cur_addr_o[16n +: 16]` shows the current address.
- R5: A write to offset 0x08 loads the command byte onto `cmd_o`. A read at 0x08 returns status: bits 3:0 are terminal-count flags, bits 7:4 are the request bits. The read clears bits 3:0 at its closing edge.
- R6: A write to offset 0x0A uses data bits 1:0 as channel index. Data bit 2 set masks that channel and clear unmasks it.
- R7: A write to 0x0E clears all mask bits. A write to 0x0F loads all mask bits from data bits 3:0.
- R8: A write to 0x09 uses data bits 1:0 as channel index and sets (bit 2 = 1) or clears that channel's request bit on `req_o`.
- R9: A write to 0x0B stores data bits 7:2 as the mode of the channel in bits 1:0, shown on `mode_o[6n +: 6]`. Within the field, bits 1:0 are the transfer type, bit 2 is auto-reload, bit 3 is decrement and bits 5:4 are the service mode.
- R10: A write to 0x0D clears the pointer, command, request and status, and sets all mask bits. Address, count and mode registers keep their values. A read at 0x0D returns 0x00.
- R11: A step on an unmasked channel with command bit 2 clear lowers the count by one and moves the address by +1, or by -1 when the mode's decrement bit is set. A step on a masked channel, or while command bit 2 is set, changes nothing.
- R12: An accepted step on a count of zero pulses `tc_o[n]` in that cycle and sets status bit n. With auto-reload the current address and count are reloaded from the base registers. Without it the count wraps to 0xFFFF, the address moves and the channel's mask bit is set. So a loaded count of N-1 gives N steps.
- R13: If a bus write hits an address or count port of the stepped channel in the same cycle, the write takes effect and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 4 | Port offset |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Write strobe, one access per cycle |
| bus_rd_i | input | 1 | Read strobe (ignored when bus_wr_i is high) |
| bus_rdata_o | output | 8 | Read data, valid while bus_rd_i is high |
| step_i | input | 1 | Transfer engine step request |
| step_ch_i | input | 2 | Channel to step |
| cmd_o | output | 8 | Command byte |
| mask_o | output | 4 | Per-channel mask bits |
| req_o | output | 4 | Per-channel software request bits |
| mode_o | output | 24 | Per-channel 6-bit mode fields |
| cur_addr_o | output | 64 | Per-channel current address |
| tc_o | output | 4 | Terminal-count pulse, same cycle as the step |

## Verification
Read data and `tc_o` are combinational, so the bench samples them a short time after driving the access or step, before the closing edge. The mask, command, request and mode outputs, the current registers and the pointer all change at the edge that ends an access. The bench therefore checks them at the following falling edge, one cycle after the stimulus. Read side effects are checked by a second access: pointer toggling on reads and status clearing are seen as the next read's value. Ignored steps are checked on `cur_addr_o`, `tc_o` and a readback of the count.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int BUS_W  = 8;
  localparam int REG_W  = 2 * BUS_W;
  localparam int OFS_W  = 4;
  localparam int MODE_W = BUS_W - 2;
  localparam int SET_BIT = 2;

  localparam logic [OFS_W-1:0] OFS_CMD     = 4'h8;
  localparam logic [OFS_W-1:0] OFS_REQ     = 4'h9;
  localparam logic [OFS_W-1:0] OFS_SMASK   = 4'hA;
  localparam logic [OFS_W-1:0] OFS_MODE    = 4'hB;
  localparam logic [OFS_W-1:0] OFS_CLRPTR  = 4'hC;
  localparam logic [OFS_W-1:0] OFS_MCLR    = 4'hD;
  localparam logic [OFS_W-1:0] OFS_CLRMASK = 4'hE;
  localparam logic [OFS_W-1:0] OFS_ALLMASK = 4'hF;

  // mode field as stored from write data bits 7:2
  typedef struct packed {
    logic [1:0] svc;
    logic       dec;
    logic       reload;
    logic [1:0] xfer;
  } mode_t;

  typedef struct packed {
    logic cmd_wr;
    logic req_wr;
    logic smask_wr;
    logic mode_wr;
    logic clrptr_wr;
    logic mclr_wr;
    logic clrmask_wr;
    logic allmask_wr;
    logic stat_rd;
    logic chan_acc;
    logic chan_wr;
    logic chan_rd;
  } strobe_t;
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
  import dma_rf_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic [OFS_W-1:0] addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output strobe_t          strb_o,
  output logic [CH_W-1:0]  ch_o,
  output logic             is_cnt_o
);
  logic rd_eff, in_chan;

  assign rd_eff  = rd_i & ~wr_i;
  assign in_chan = int'(addr_i) < 2 * NCH;
  assign ch_o    = addr_i[CH_W:1];
  assign is_cnt_o = addr_i[0];

  always_comb begin
    strb_o            = '0;
    strb_o.chan_acc   = in_chan & (wr_i | rd_eff);
    strb_o.chan_wr    = in_chan & wr_i;
    strb_o.chan_rd    = in_chan & rd_eff;
    strb_o.cmd_wr     = wr_i & (addr_i == OFS_CMD);
    strb_o.req_wr     = wr_i & (addr_i == OFS_REQ);
    strb_o.smask_wr   = wr_i & (addr_i == OFS_SMASK);
    strb_o.mode_wr    = wr_i & (addr_i == OFS_MODE);
    strb_o.clrptr_wr  = wr_i & (addr_i == OFS_CLRPTR);
    strb_o.mclr_wr    = wr_i & (addr_i == OFS_MCLR);
    strb_o.clrmask_wr = wr_i & (addr_i == OFS_CLRMASK);
    strb_o.allmask_wr = wr_i & (addr_i == OFS_ALLMASK);
    strb_o.stat_rd    = rd_eff & (addr_i == OFS_CMD);
  end
endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
  import dma_rf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_addr_i,
  input  logic             wr_cnt_i,
  input  logic             byte_hi_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             step_i,
  input  logic             dec_i,
  input  logic             reload_i,
  output logic [REG_W-1:0] cur_addr_o,
  output logic [REG_W-1:0] cur_cnt_o,
  output logic             tc_o
);
  logic [REG_W-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;

  assign tc_o       = step_i & (cur_cnt_q == '0);
  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
    end else if (wr_addr_i) begin
      if (byte_hi_i) begin
        base_addr_q[REG_W-1:BUS_W] <= wdata_i;
        cur_addr_q[REG_W-1:BUS_W]  <= wdata_i;
      end else begin
        base_addr_q[BUS_W-1:0] <= wdata_i;
        cur_addr_q[BUS_W-1:0]  <= wdata_i;
      end
    end else if (wr_cnt_i) begin
      if (byte_hi_i) begin
        base_cnt_q[REG_W-1:BUS_W] <= wdata_i;
        cur_cnt_q[REG_W-1:BUS_W]  <= wdata_i;
      end else begin
        base_cnt_q[BUS_W-1:0] <= wdata_i;
        cur_cnt_q[BUS_W-1:0]  <= wdata_i;
      end
    end else if (step_i) begin
      if (tc_o && reload_i) begin
        cur_addr_q <= base_addr_q;
        cur_cnt_q  <= base_cnt_q;
      end else begin
        cur_cnt_q  <= cur_cnt_q - 1'b1;
        cur_addr_q <= dec_i ? cur_addr_q - 1'b1 : cur_addr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_rf_ctrl.sv
module dma_rf_ctrl
  import dma_rf_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  strobe_t            strb_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic [NCH-1:0]     tc_i,
  output logic [BUS_W-1:0]   cmd_o,
  output logic [NCH-1:0]     mask_o,
  output logic [NCH-1:0]     req_o,
  output logic [NCH-1:0]     tcst_o,
  output mode_t              mode_o [NCH],
  output logic               byte_hi_o
);
  logic [BUS_W-1:0] cmd_q;
  logic [NCH-1:0]   mask_q, mask_d, req_q, tcst_q, reload_v;
  mode_t            mode_q [NCH];
  logic             ptr_q;
  logic [CH_W-1:0]  sel;

  assign sel = wdata_i[CH_W-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_reload
    assign reload_v[c] = mode_q[c].reload;
    assign mode_o[c]   = mode_q[c];
  end

  always_comb begin
    mask_d = mask_q;
    if (strb_i.mclr_wr)         mask_d = '1;
    else if (strb_i.clrmask_wr) mask_d = '0;
    else if (strb_i.allmask_wr) mask_d = wdata_i[NCH-1:0];
    else if (strb_i.smask_wr)   mask_d[sel] = wdata_i[SET_BIT];
    // terminal count without reload parks the channel
    mask_d = mask_d | (tc_i & ~reload_v);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      mask_q <= '1;
      req_q  <= '0;
      tcst_q <= '0;
      ptr_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      if (strb_i.mclr_wr) begin
        cmd_q  <= '0;
        req_q  <= '0;
        tcst_q <= '0;
        ptr_q  <= 1'b0;
      end else begin
        if (strb_i.cmd_wr) cmd_q <= wdata_i;
        if (strb_i.req_wr) req_q[sel] <= wdata_i[SET_BIT];
        tcst_q <= (strb_i.stat_rd ? '0 : tcst_q) | tc_i;
        if (strb_i.clrptr_wr)     ptr_q <= 1'b0;
        else if (strb_i.chan_acc) ptr_q <= ~ptr_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) mode_q[c] <= '0;
    end else if (strb_i.mode_wr) begin
      mode_q[sel] <= mode_t'(wdata_i[BUS_W-1:BUS_W-MODE_W]);
    end
  end

  assign cmd_o     = cmd_q;
  assign mask_o    = mask_q;
  assign req_o     = req_q;
  assign tcst_o    = tcst_q;
  assign byte_hi_o = ptr_q;
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [OFS_W-1:0]      bus_addr_i,
  input  logic [BUS_W-1:0]      bus_wdata_i,
  input  logic                  bus_wr_i,
  input  logic                  bus_rd_i,
  output logic [BUS_W-1:0]      bus_rdata_o,
  input  logic                  step_i,
  input  logic [CH_W-1:0]       step_ch_i,
  output logic [BUS_W-1:0]      cmd_o,
  output logic [NCH-1:0]        mask_o,
  output logic [NCH-1:0]        req_o,
  output logic [NCH*MODE_W-1:0] mode_o,
  output logic [NCH*REG_W-1:0]  cur_addr_o,
  output logic [NCH-1:0]        tc_o
);
  strobe_t          strb;
  logic [CH_W-1:0]  port_ch;
  logic             port_cnt;
  logic             byte_hi;
  logic [NCH-1:0]   tcst;
  mode_t            mode_v [NCH];
  logic [REG_W-1:0] cur_addr [NCH];
  logic [REG_W-1:0] cur_cnt  [NCH];
  logic [REG_W-1:0] rd_word;

  dma_rf_decode #(.NCH(NCH)) i_decode (
    .addr_i   (bus_addr_i),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .strb_o   (strb),
    .ch_o     (port_ch),
    .is_cnt_o (port_cnt)
  );

  dma_rf_ctrl #(.NCH(NCH)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strb_i    (strb),
    .wdata_i   (bus_wdata_i),
    .tc_i      (tc_o),
    .cmd_o     (cmd_o),
    .mask_o    (mask_o),
    .req_o     (req_o),
    .tcst_o    (tcst),
    .mode_o    (mode_v),
    .byte_hi_o (byte_hi)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic sel_c, wr_hit, step_en;

    assign sel_c   = (port_ch == CH_W'(c));
    assign wr_hit  = strb.chan_wr & sel_c;
    // bus write to this channel wins over a step
    assign step_en = step_i & (step_ch_i == CH_W'(c)) & ~mask_o[c] & ~cmd_o[2] & ~wr_hit;

    dma_rf_chan i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_addr_i  (wr_hit & ~port_cnt),
      .wr_cnt_i   (wr_hit & port_cnt),
      .byte_hi_i  (byte_hi),
      .wdata_i    (bus_wdata_i),
      .step_i     (step_en),
      .dec_i      (mode_v[c].dec),
      .reload_i   (mode_v[c].reload),
      .cur_addr_o (cur_addr[c]),
      .cur_cnt_o  (cur_cnt[c]),
      .tc_o       (tc_o[c])
    );

    assign cur_addr_o[c*REG_W +: REG_W] = cur_addr[c];
    assign mode_o[c*MODE_W +: MODE_W]   = mode_v[c];
  end

  assign rd_word = port_cnt ? cur_cnt[port_ch] : cur_addr[port_ch];

  always_comb begin
    bus_rdata_o = '0;
    if (strb.chan_rd)      bus_rdata_o = byte_hi ? rd_word[REG_W-1:BUS_W] : rd_word[BUS_W-1:0];
    else if (strb.stat_rd) bus_rdata_o = BUS_W'({req_o, tcst});
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
  parameter int NCH = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [3:0]          bus_addr_i,
  input logic [7:0]          bus_wdata_i,
  input logic                bus_wr_i,
  input logic                bus_rd_i,
  input logic                step_i,
  input logic [1:0]          step_ch_i,
  input logic [7:0]          cmd_o,
  input logic [NCH-1:0]      mask_o,
  input logic [NCH-1:0]      req_o,
  input logic [NCH*6-1:0]    mode_o,
  input logic [NCH-1:0]      tc_o,
  input logic                byte_hi_i
);
  logic chan_acc;
  assign chan_acc = (bus_wr_i | bus_rd_i) && (int'(bus_addr_i) < 2 * NCH);

  p_ptr_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_acc |=> byte_hi_i != $past(byte_hi_i));

  p_ptr_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == 4'hC) |=> !byte_hi_i);

  p_single_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == 4'hA && tc_o == '0)
      |=> mask_o[$past(bus_wdata_i[1:0])] == $past(bus_wdata_i[2]));

  p_clear_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == 4'hE && tc_o == '0) |=> mask_o == '0);

  p_master_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == 4'hD)
      |=> (mask_o == '1 && cmd_o == '0 && req_o == '0 && !byte_hi_i));

  p_blocked_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && (mask_o[step_ch_i] || cmd_o[2])) |-> tc_o == '0);

  p_tc_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tc_o));

  p_tc_parks_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o[step_ch_i] && !mode_o[6*int'(step_ch_i)+2]) |=> mask_o[$past(step_ch_i)]);
endmodule

bind dma_regfile dma_regfile_chk #(.NCH(NCH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .step_i      (step_i),
  .step_ch_i   (step_ch_i),
  .cmd_o       (cmd_o),
  .mask_o      (mask_o),
  .req_o       (req_o),
  .mode_o      (mode_o),
  .tc_o        (tc_o),
  .byte_hi_i   (byte_hi)
);

// File: tb/test_dma_regfile.sv
module test_dma_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic        step = 1'b0;
  logic [1:0]  step_ch = '0;
  logic [7:0]  cmd;
  logic [3:0]  mask, req, tc;
  logic [23:0] mode;
  logic [63:0] cur_addr;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  dma_regfile i_dma_regfile (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_rdata_o(rdata), .step_i(step),
    .step_ch_i(step_ch), .cmd_o(cmd), .mask_o(mask), .req_o(req),
    .mode_o(mode), .cur_addr_o(cur_addr), .tc_o(tc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #2 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_step(input logic [1:0] ch, output logic [3:0] t);
    step = 1'b1; step_ch = ch;
    #2 t = tc;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 mask", 64'(mask), 64'hF);
    chk("R1 cmd/req", 64'({cmd, req}), 64'h0);
    chk("R1 addr", cur_addr, 64'h0);
    bus_rd(4'h8, d);
    chk("R1 status", 64'(d), 64'h0);
    bus_rd(4'h1, d);
    chk("R1 count low", 64'(d), 64'h0);
    bus_wr(4'hC, 8'h00);
  endtask

  task automatic t_chan_regs;
    logic [7:0] a0, a1, c0, c1;
    bus_wr(4'h4, 8'h34); bus_wr(4'h4, 8'h12);
    bus_wr(4'h5, 8'h05); bus_wr(4'h5, 8'h00);
    chk("R4 cur_addr ch2", 64'(cur_addr[47:32]), 64'h1234);
    bus_rd(4'h4, a0); bus_rd(4'h4, a1);
    bus_rd(4'h5, c0); bus_rd(4'h5, c1);
    chk("R2 R4 addr bytes", 64'({a1, a0}), 64'h1234);
    chk("R4 count bytes", 64'({c1, c0}), 64'h0005);
  endtask

  task automatic t_clr_ptr;
    logic [7:0] a0, a1;
    bus_wr(4'h2, 8'hAA);
    bus_wr(4'hC, 8'hFF);
    bus_wr(4'h2, 8'h55); bus_wr(4'h2, 8'h66);
    bus_rd(4'h2, a0);
    bus_wr(4'hC, 8'h5A);
    bus_rd(4'h2, a1);
    chk("R3 low after clear", 64'(a0), 64'h55);
    chk("R3 read toggled then cleared", 64'(a1), 64'h55);
    bus_rd(4'h2, a1);
    chk("R2 high after low read", 64'(a1), 64'h66);
  endtask

  task automatic t_mask;
    bus_wr(4'hF, 8'h00); chk("R7 all clear", 64'(mask), 64'h0);
    bus_wr(4'hA, 8'h06); chk("R6 mask ch2", 64'(mask), 64'h4);
    bus_wr(4'hA, 8'h02); chk("R6 unmask ch2", 64'(mask), 64'h0);
    bus_wr(4'hF, 8'hFB); chk("R7 all write", 64'(mask), 64'hB);
    bus_wr(4'hE, 8'h00); chk("R7 clear all", 64'(mask), 64'h0);
    bus_wr(4'hF, 8'h0F);
  endtask

  task automatic t_mode;
    bus_wr(4'hB, 8'h59); chk("R9 mode ch1", 64'(mode[11:6]), 64'h16);
    bus_wr(4'hB, 8'hE7); chk("R9 mode ch3", 64'(mode[23:18]), 64'h39);
    chk("R9 ch0 untouched", 64'(mode[5:0]), 64'h0);
  endtask

  task automatic t_request;
    logic [7:0] d;
    bus_wr(4'h9, 8'h06); chk("R8 req ch2", 64'(req), 64'h4);
    bus_rd(4'h8, d);     chk("R5 status req", 64'(d), 64'h40);
    bus_wr(4'h9, 8'h02); chk("R8 req clear", 64'(req), 64'h0);
    bus_wr(4'h8, 8'hA5); chk("R5 cmd", 64'(cmd), 64'hA5);
    bus_wr(4'h8, 8'h00);
  endtask

  task automatic t_step;
    logic [7:0] d0, d1;
    logic [3:0] t;
    bus_wr(4'hB, 8'h44);
    bus_wr(4'hC, 8'h00);
    bus_wr(4'h0, 8'hFF); bus_wr(4'h0, 8'h00);
    bus_wr(4'h1, 8'h02); bus_wr(4'h1, 8'h00);
    bus_wr(4'hA, 8'h00);
    do_step(2'd0, t);
    chk("R11 addr inc", 64'(cur_addr[15:0]), 64'h0100);
    bus_rd(4'h1, d0); bus_rd(4'h1, d1);
    chk("R11 count dec", 64'({d1, d0}), 64'h0001);
    do_step(2'd0, t);
    chk("R12 no tc early", 64'(t), 64'h0);
    do_step(2'd0, t);
    chk("R12 tc pulse", 64'(t), 64'h1);
    chk("R12 masked after tc", 64'(mask[0]), 64'h1);
    chk("R12 addr moved", 64'(cur_addr[15:0]), 64'h0102);
    bus_rd(4'h1, d0); bus_rd(4'h1, d1);
    chk("R12 count wrap", 64'({d1, d0}), 64'hFFFF);
    bus_rd(4'h8, d0); bus_rd(4'h8, d1);
    chk("R5 status tc", 64'(d0), 64'h01);
    chk("R5 status cleared", 64'(d1), 64'h00);
    do_step(2'd0, t);
    chk("R11 masked step", 64'({t, cur_addr[15:0]}), 64'h0_0102);
  endtask

  task automatic t_cmd_disable;
    logic [3:0] t;
    bus_wr(4'h8, 8'h04);
    bus_wr(4'hA, 8'h00);
    do_step(2'd0, t);
    chk("R11 disabled step", 64'({t, cur_addr[15:0]}), 64'h0_0102);
    bus_wr(4'h8, 8'h00);
    bus_wr(4'hA, 8'h04);
  endtask

  task automatic t_reload_dec;
    logic [7:0] d0, d1;
    logic [3:0] t;
    bus_wr(4'hB, 8'h77);
    bus_wr(4'hC, 8'h00);
    bus_wr(4'h6, 8'h00); bus_wr(4'h6, 8'h10);
    bus_wr(4'h7, 8'h01); bus_wr(4'h7, 8'h00);
    bus_wr(4'hA, 8'h03);
    do_step(2'd3, t);
    chk("R11 addr dec", 64'(cur_addr[63:48]), 64'h0FFF);
    do_step(2'd3, t);
    chk("R12 tc ch3", 64'(t), 64'h8);
    chk("R12 reload addr", 64'(cur_addr[63:48]), 64'h1000);
    chk("R12 reload keeps unmasked", 64'(mask[3]), 64'h0);
    bus_rd(4'h7, d0); bus_rd(4'h7, d1);
    chk("R12 reload count", 64'({d1, d0}), 64'h0001);
    bus_rd(4'h8, d0);
    chk("R5 status ch3", 64'(d0), 64'h08);
  endtask

  task automatic t_conflict;
    logic [7:0] d0, d1;
    bus_wr(4'hC, 8'h00);
    addr = 4'h7; wdata = 8'h20; wr = 1'b1; step = 1'b1; step_ch = 2'd3;
    @(negedge clk);
    wr = 1'b0; step = 1'b0;
    chk("R13 addr unchanged", 64'(cur_addr[63:48]), 64'h1000);
    bus_wr(4'hC, 8'h00);
    bus_rd(4'h7, d0); bus_rd(4'h7, d1);
    chk("R13 write wins", 64'({d1, d0}), 64'h0020);
  endtask

  task automatic t_master_clear;
    logic [7:0] d0, d1;
    bus_wr(4'h9, 8'h05);
    bus_wr(4'h8, 8'h10);
    bus_wr(4'h0, 8'h11);
    bus_wr(4'hD, 8'h00);
    chk("R10 mask set", 64'(mask), 64'hF);
    chk("R10 cmd/req", 64'({cmd, req}), 64'h0);
    chk("R10 regs kept", 64'(cur_addr[47:32]), 64'h1234);
    chk("R10 mode kept", 64'(mode[23:18]), 64'h1D);
    bus_rd(4'hD, d0);
    chk("R10 temp read", 64'(d0), 64'h00);
    bus_rd(4'h4, d0); bus_rd(4'h4, d1);
    chk("R10 ptr low", 64'({d1, d0}), 64'h1234);
    bus_rd(4'h8, d0);
    chk("R10 status clear", 64'(d0), 64'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chan_regs();
    t_clr_ptr();
    t_mask();
    t_mode();
    t_request();
    t_step();
    t_cmd_disable();
    t_reload_dec();
    t_conflict();
    t_master_clear();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule